// File: doc/BRIEF.md
# Period-Match Timer with Prescaler and Postscaler

The block is a free-running up-counter with a programmable terminal value. A tick input, normally a fixed fraction of the system clock, first passes through a prescaler that divides it by 1, 4 or 16. Each prescaled tick advances the counter. When the counter already equals the period value at a prescaled tick, it returns to zero and a match event occurs. The block shows each match event on a one-cycle output pulse that can drive a serial shift clock. Match events also feed a postscaler that divides them by 1 to 16 before it sets a sticky interrupt flag.

Software reaches three registers through a write strobe, a write address and data, and a separate read address. The registers are the count, the period and the control register. Read data is registered and appears one cycle after the address is presented. The control register holds the run enable, the prescale select and the postscale select. Any write to the count or control register restarts both dividers. A control write never disturbs the count.

Top module: `pmatch_timer`

## Requirements
- R1: Register addresses are 0 for the count, 1 for the period and 2 for the control register. Address 3 reads as zero. A write to any of the three stores wr_data, and rd_data shows the register selected by rd_addr one clock after that address is sampled.
- R2: Control bits 1:0 select the prescale ratio: 00 gives one prescaled tick per tick_in pulse, 01 gives one per 4 pulses, and 10 or 11 give one per 16 pulses. Pulses are counted only while enabled.
- R3: On each prescaled tick the count increments by one. If the count equals the period at that tick, it becomes 00h instead, and match_o is high for exactly the following cycle.
- R4: Control bits 6:3 hold a postscale value N. irq_o is set on every (N+1)-th match event counted since the dividers were last cleared.
- R5: irq_o stays high until irq_clr is asserted. If a new set and a clear fall in the same cycle, the set wins.
- R6: After reset the count reads 00h, the period reads FFh, the control register reads 00h, and match_o and irq_o are low.
- R7: A write to the count or control register clears the prescale and postscale counters and suppresses any tick in that cycle. A control write leaves the count unchanged.
- R8: Control bit 7 always reads 0. While enable (control bit 2) is 0, the count holds and no match occurs.
- R9: With a period of 00h, every prescaled tick is a match event and the count stays at 00h.
- R10: A write to the count takes priority over an increment in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_in | input | 1 | Count-enable pulse from the clock divider |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Registered read data |
| irq_clr | input | 1 | Clears the interrupt flag |
| match_o | output | 1 | One-cycle pulse per match event |
| irq_o | output | 1 | Sticky interrupt flag |

## Verification
A fault in the prescale counter moves every later increment, so the count seen through rd_data drifts from its expected value within one prescale period. A wrong count or period compare shows up in the cycle after the next prescaled tick, as a match_o pulse that is missing or comes too early. A postscale counter that is off by one moves the set of irq_o by a whole match period. Because the flag is sticky, the error stays visible until the next clear.

// File: rtl/pmt_pkg.sv
package pmt_pkg;
  typedef enum logic [1:0] {
    REG_COUNT  = 2'd0,
    REG_PERIOD = 2'd1,
    REG_CTRL   = 2'd2,
    REG_SPARE  = 2'd3
  } reg_sel_e;

  // control field positions
  localparam int unsigned CTL_PRE_LSB  = 0;
  localparam int unsigned CTL_RUN_BIT  = 2;
  localparam int unsigned CTL_POST_LSB = 3;
  localparam int unsigned CTL_WIDTH    = 7;

  // terminal value of the prescale counter for a given select code
  function automatic logic [3:0] pre_limit(input logic [1:0] sel);
    logic [3:0] lim;
    if (sel[1])      lim = 4'd15;
    else if (sel[0]) lim = 4'd3;
    else             lim = 4'd0;
    return lim;
  endfunction
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int unsigned PW = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic       run,
  input  logic       tick,
  input  logic [1:0] sel,
  output logic       step
);
  logic [PW-1:0] pc_q;
  logic [PW-1:0] lim;

  assign lim  = PW'(pmt_pkg::pre_limit(sel));
  assign step = run && tick && !clr && (pc_q == lim);

  always_ff @(posedge clk) begin
    if (rst || clr)       pc_q <= '0;
    else if (run && tick) pc_q <= (pc_q == lim) ? '0 : pc_q + 1'b1;
  end

  // R2
  pre_bound_chk: assert property (@(posedge clk) disable iff (rst)
    pc_q <= lim);
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  input  logic          wr_cnt,
  input  logic          wr_per,
  input  logic [CW-1:0] wdata,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] per,
  output logic          hit
);
  logic [CW-1:0] cnt_q, per_q;

  assign hit = step && (cnt_q == per_q);
  assign cnt = cnt_q;
  assign per = per_q;

  always_ff @(posedge clk) begin
    if (rst)         cnt_q <= '0;
    else if (wr_cnt) cnt_q <= wdata;
    else if (step)   cnt_q <= hit ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)         per_q <= '1;
    else if (wr_per) per_q <= wdata;
  end

  // R9
  zero_period_chk: assert property (@(posedge clk) disable iff (rst)
    (per_q == '0 && cnt_q == '0 && !wr_cnt) |=> cnt_q == '0);
  // R10
  write_wins_chk: assert property (@(posedge clk) disable iff (rst)
    wr_cnt |=> cnt_q == $past(wdata));
endmodule

// File: rtl/tmr_postscale.sv
module tmr_postscale #(
  parameter int unsigned SW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          hit,
  input  logic [SW-1:0] sel,
  output logic          fire
);
  logic [SW-1:0] ps_q;

  assign fire = hit && (ps_q == sel);

  always_ff @(posedge clk) begin
    if (rst || clr) ps_q <= '0;
    else if (hit)   ps_q <= fire ? '0 : ps_q + 1'b1;
  end

  // R4
  post_bound_chk: assert property (@(posedge clk) disable iff (rst || clr)
    hit |-> ps_q <= sel);
endmodule

// File: rtl/pmatch_timer.sv
module pmatch_timer #(
  parameter int unsigned CW = 8,
  parameter int unsigned PW = 4,
  parameter int unsigned SW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_in,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [CW-1:0] wr_data,
  input  logic [1:0]    rd_addr,
  output logic [CW-1:0] rd_data,
  input  logic          irq_clr,
  output logic          match_o,
  output logic          irq_o
);
  import pmt_pkg::*;
  localparam int unsigned CTW = CTL_WIDTH;

  logic [CTW-1:0] ctl_q;
  logic           wr_cnt, wr_per, wr_ctl, div_clr;
  logic           step, hit, fire;
  logic [CW-1:0]  cnt, per;
  logic           match_q, irq_q;
  logic [CW-1:0]  rd_q;

  assign wr_cnt  = wr_en && (wr_addr == REG_COUNT);
  assign wr_per  = wr_en && (wr_addr == REG_PERIOD);
  assign wr_ctl  = wr_en && (wr_addr == REG_CTRL);
  assign div_clr = wr_cnt || wr_ctl;

  always_ff @(posedge clk) begin
    if (rst)         ctl_q <= '0;
    else if (wr_ctl) ctl_q <= wr_data[CTW-1:0];
  end

  tmr_prescale #(.PW(PW)) u_pre (
    .clk(clk), .rst(rst), .clr(div_clr), .run(ctl_q[CTL_RUN_BIT]),
    .tick(tick_in), .sel(ctl_q[CTL_PRE_LSB +: 2]), .step(step));

  tmr_count #(.CW(CW)) u_cnt (
    .clk(clk), .rst(rst), .step(step), .wr_cnt(wr_cnt), .wr_per(wr_per),
    .wdata(wr_data), .cnt(cnt), .per(per), .hit(hit));

  tmr_postscale #(.SW(SW)) u_post (
    .clk(clk), .rst(rst), .clr(div_clr), .hit(hit),
    .sel(ctl_q[CTL_POST_LSB +: SW]), .fire(fire));

  always_ff @(posedge clk) begin
    if (rst) begin
      match_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      match_q <= hit;
      irq_q   <= fire || (irq_q && !irq_clr);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else begin
      case (reg_sel_e'(rd_addr))
        REG_COUNT:  rd_q <= cnt;
        REG_PERIOD: rd_q <= per;
        REG_CTRL:   rd_q <= CW'(ctl_q);
        default:    rd_q <= '0;
      endcase
    end
  end

  assign rd_data = rd_q;
  assign match_o = match_q;
  assign irq_o   = irq_q;

  // R5
  irq_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_o && !irq_clr) |=> irq_o);
  // R8
  halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!ctl_q[CTL_RUN_BIT] && !wr_cnt) |=> ($stable(cnt) && !match_o));
  // R3
  match_cause_chk: assert property (@(posedge clk) disable iff (rst)
    match_o |-> ($past(cnt) == $past(per) && cnt == '0));
  // R7
  ctl_keeps_cnt_chk: assert property (@(posedge clk) disable iff (rst)
    wr_ctl |=> $stable(cnt));
endmodule

// File: tb/pmatch_timer_bench.sv
module pmatch_timer_bench;
  localparam int CLK_P = 10;

  logic       clk = 1'b0, rst = 1'b1;
  logic       tick_in = 1'b0, wr_en = 1'b0, irq_clr = 1'b0;
  logic [1:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       match_o, irq_o;

  int total = 0, bad = 0;
  bit done = 0;

  pmatch_timer u_pmatch_timer (
    .clk(clk), .rst(rst), .tick_in(tick_in), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq_clr(irq_clr),
    .match_o(match_o), .irq_o(irq_o));

  always #(CLK_P/2) clk = ~clk;

  // reference model, built from the requirements
  logic [7:0] m_cnt, m_per, m_rd;
  logic [6:0] m_ctl;
  logic [3:0] m_pc, m_ps;
  logic       m_irq, m_match;

  function automatic logic [3:0] lim_of(input logic [1:0] s);
    return s[1] ? 4'd15 : (s[0] ? 4'd3 : 4'd0);
  endfunction

  always @(posedge clk) begin
    logic clr, pt, mev, fire;
    logic [3:0] lim;
    if (rst) begin
      m_cnt = 0; m_per = 8'hFF; m_ctl = 0; m_pc = 0; m_ps = 0;
      m_irq = 0; m_match = 0; m_rd = 0;
    end else begin
      clr  = wr_en && (wr_addr == 0 || wr_addr == 2);
      lim  = lim_of(m_ctl[1:0]);
      pt   = m_ctl[2] && tick_in && !clr && (m_pc == lim);
      mev  = pt && (m_cnt == m_per);
      fire = mev && (m_ps == m_ctl[6:3]);
      case (rd_addr)
        2'd0: m_rd = m_cnt;
        2'd1: m_rd = m_per;
        2'd2: m_rd = {1'b0, m_ctl};
        default: m_rd = 0;
      endcase
      if (clr) m_pc = 0;
      else if (m_ctl[2] && tick_in) m_pc = (m_pc == lim) ? 4'd0 : m_pc + 4'd1;
      if (clr) m_ps = 0;
      else if (mev) m_ps = fire ? 4'd0 : m_ps + 4'd1;
      if (wr_en && wr_addr == 0) m_cnt = wr_data;
      else if (pt) m_cnt = mev ? 8'd0 : m_cnt + 8'd1;
      if (wr_en && wr_addr == 1) m_per = wr_data;
      if (wr_en && wr_addr == 2) m_ctl = wr_data[6:0];
      m_irq   = fire || (m_irq && !irq_clr);
      m_match = mev;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(rd_data == m_rd, "R1 rd_data", rd_data, m_rd);
      chk(match_o == m_match, "R3 match_o", match_o, m_match);
      chk(irq_o == m_irq, "R5 irq_o", irq_o, m_irq);
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    rd_addr = a;
    @(negedge clk);
    v = rd_data;
  endtask

  task automatic ticks(input int n);
    tick_in = 1;
    repeat (n) @(negedge clk);
    tick_in = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, c1;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R6 reset state
    chk(match_o == 0 && irq_o == 0, "R6 outputs", {match_o, irq_o}, 0);
    rd(0, v); chk(v == 8'h00, "R6 count", v, 8'h00);
    rd(1, v); chk(v == 8'hFF, "R6 period", v, 8'hFF);
    rd(2, v); chk(v == 8'h00, "R6 control", v, 8'h00);
    rd(3, v); chk(v == 8'h00, "R1 spare", v, 8'h00);

    // R8 bit 7 reads zero, and a disabled timer holds
    wr(2, 8'hFB); rd(2, v); chk(v == 8'h7B, "R8 ctl bit7", v, 8'h7B);
    wr(2, 8'h00); wr(0, 8'h21);
    ticks(20); rd(0, v); chk(v == 8'h21, "R8 hold", v, 8'h21);

    // R2 divide-by-1, -4 and -16
    wr(0, 0); wr(2, 8'h04); ticks(5); rd(0, v); chk(v == 5, "R2 div1", v, 5);
    wr(0, 0); wr(2, 8'h05); ticks(4*6+3); rd(0, v); chk(v == 6, "R2 div4", v, 6);
    wr(0, 0); wr(2, 8'h06); ticks(16*3); rd(0, v); chk(v == 3, "R2 div16 10", v, 3);
    wr(0, 0); wr(2, 8'h07); ticks(16*2+15); rd(0, v); chk(v == 2, "R2 div16 11", v, 2);

    // R7 control write keeps the count and clears the prescaler
    wr(2, 8'h05); ticks(2); rd(0, c1);
    wr(2, 8'h05); rd(0, v); chk(v == c1, "R7 count kept", v, c1);
    ticks(3); rd(0, v); chk(v == c1, "R7 prescale cleared", v, c1);
    ticks(1); rd(0, v); chk(v == c1 + 1, "R7 after 4", v, c1 + 1);

    // R10 count write beats a tick in the same cycle
    wr(2, 8'h04); tick_in = 1; wr(0, 8'h40); tick_in = 0;
    rd(0, v); chk(v == 8'h40, "R10 write wins", v, 8'h40);

    // R4 period 3, prescale 4, postscale 1:2 -> irq after 32 ticks
    wr(2, 8'h00); wr(0, 0); wr(1, 8'd3);
    irq_clr = 1; @(negedge clk); irq_clr = 0;
    tick_in = 1; wr(2, 8'h0D);
    for (int k = 1; k <= 32; k++) begin
      @(negedge clk);
      if (k == 15) chk(!match_o, "R3 no early match", match_o, 0);
      if (k == 16) chk(match_o, "R3 first match", match_o, 1);
      if (k == 16) chk(!irq_o, "R4 not on first match", irq_o, 0);
      if (k == 31) chk(!irq_o, "R4 not yet", irq_o, 0);
      if (k == 32) chk(irq_o, "R4 set on 2nd match", irq_o, 1);
    end
    tick_in = 0;
    repeat (5) @(negedge clk);
    chk(irq_o, "R5 sticky", irq_o, 1);
    irq_clr = 1; @(negedge clk); irq_clr = 0;
    chk(!irq_o, "R5 cleared", irq_o, 0);

    // R9 zero period matches on every prescaled tick
    wr(2, 8'h00); wr(0, 0); wr(1, 8'h00); wr(2, 8'h04);
    tick_in = 1;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      chk(match_o, "R9 match each tick", match_o, 1);
    end
    tick_in = 0;
    rd(0, v); chk(v == 0, "R9 count zero", v, 0);

    // random traffic checked by the model
    for (int i = 0; i < 4000; i++) begin
      logic [1:0] a;
      tick_in = ($urandom % 4) != 0;
      irq_clr = ($urandom % 10) == 0;
      rd_addr = 2'($urandom);
      wr_en   = ($urandom % 12) == 0;
      a = 2'($urandom);
      wr_addr = a;
      if (a == 1) wr_data = 8'($urandom % 7);
      else if (a == 2) wr_data = 8'($urandom) | 8'h04;
      else wr_data = 8'($urandom % 8);
      @(negedge clk);
    end
    wr_en = 0; tick_in = 0; irq_clr = 0;
    repeat (3) @(negedge clk);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule